// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block drives a set of general-purpose pin banks for a radio front end that is half duplex. Software owns every pin through a plain output register and an output-enable register. Any pin can instead be put under automatic control. Such a pin shows one of two preset values, and the choice follows whether the transmit FIFO currently holds samples. Antenna switches, amplifier enables and receive enables can then follow the data stream without software acting on each burst.

Each bank has five 16-bit registers: output, output enable, switch mask, transmit value and receive value. All five are updated through a masked write, so one write changes only the bits it names. Two shared delay registers set how many clock cycles the FIFO state must hold before the pins move, one for each direction of the change. A readback port returns the live pin inputs of a bank pair, so software can sample status lines such as a synthesizer lock flag.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: After reset every register is zero: all `pin_oe` bits are 0, all `pin_out` bits are 0, and the block is in receive mode with both delays at 0.
- R2: A write with `wr_addr[5]`=0 targets bank `wr_addr[4:3]`. The field is chosen by `wr_addr[2:0]`: 0 output, 1 output enable, 2 switch mask, 3 transmit value, 4 receive value. Only the bits set in `wr_data[31:16]` are replaced, and they take the value of the matching bits of `wr_data[15:0]`. The new value shows on the pins in the cycle after the write edge.
- R3: A `pin_out` bit whose mask bit is 0 shows the output register bit. A bit whose mask bit is 1 shows the automatically selected bit.
- R4: In transmit mode the masked bits show the transmit value. In receive mode they show the receive value.
- R5: `pin_oe` equals the output-enable registers at all times, whatever the switching logic selects.
- R6: `fifo_ne` passes through two flip-flops before use. With a delay of 0, a level that is present before clock edge e shows on the pins just after edge e+2.
- R7: Address 32 (`wr_addr[5]`=1, `wr_addr[4:0]`=0) holds the receive-to-transmit delay D, and address 33 holds the transmit-to-receive delay. The delay is taken from `wr_data[15:0]` and the mask half is not used. The mode changes D cycles later than R6 gives, and only if the synchronised FIFO state has stayed at its new level for the whole window. A return to the old level during the window cancels the change.
- R8: `rd_data` is combinational: bits 31:16 carry `pin_in` of bank 2·`rd_sel`+1 and bits 15:0 carry `pin_in` of bank 2·`rd_sel`.
- R9: A write to field codes 5 to 7, or to a global address other than 32 and 33, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 32 | Write mask (31:16) and value (15:0) |
| rd_sel | input | 1 | Bank pair selected for readback |
| rd_data | output | 32 | Pin inputs of the selected pair |
| fifo_ne | input | 1 | Transmit FIFO holds data (asynchronous) |
| pin_out | output | 64 | Output value of every pin, bank 0 in the low bits |
| pin_oe | output | 64 | Output enable of every pin, 1 drives the pin |
| pin_in | input | 64 | Sampled level of every pin |

## Verification
Register writes reach the pins one cycle after the write edge. Readback is due in the same cycle as its inputs. A FIFO change reaches the pins 2+D edges after the edge that first samples it. The bench drives its inputs on falling edges. It advances a behavioural model on each rising edge and compares all outputs 2 ns after that edge, so every result is checked in the cycle it is due. Directed checks at falling edges pin the exact switching cycle for delays 0 and 3, and confirm that a pulse shorter than the delay window is cancelled.

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl #(
  parameter int NBANK = 4,
  parameter int WIDTH = 16,
  parameter int DLYW  = 16,
  localparam int BW   = $clog2(NBANK),
  localparam int AW   = BW + 4,
  localparam int SW   = (NBANK > 2) ? $clog2(NBANK / 2) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [2*WIDTH-1:0]     wr_data,
  input  logic [SW-1:0]          rd_sel,
  output logic [2*WIDTH-1:0]     rd_data,
  input  logic                   fifo_ne,
  output logic [NBANK*WIDTH-1:0] pin_out,
  output logic [NBANK*WIDTH-1:0] pin_oe,
  input  logic [NBANK*WIDTH-1:0] pin_in
);

  logic            sync1, ne_s, tx_mode;
  logic [DLYW-1:0] dly_r2t, dly_t2r, cnt;

  wire             is_glb = wr_addr[AW-1];
  wire [BW-1:0]    wbank  = wr_addr[BW+2:3];
  wire [2:0]       wfld   = wr_addr[2:0];
  wire [WIDTH-1:0] wm     = wr_data[2*WIDTH-1:WIDTH];
  wire [WIDTH-1:0] wv     = wr_data[WIDTH-1:0];
  wire [DLYW-1:0]  need   = ne_s ? dly_r2t : dly_t2r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 1'b0;
      ne_s  <= 1'b0;
    end else begin
      sync1 <= fifo_ne;
      ne_s  <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_mode <= 1'b0;
      cnt     <= '0;
    end else if (ne_s == tx_mode) begin
      cnt <= '0;
    end else if (cnt >= need) begin
      tx_mode <= ne_s;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly_r2t <= '0;
      dly_t2r <= '0;
    end else if (wr_en && is_glb && wr_addr[AW-2:1] == '0) begin
      if (wr_addr[0]) dly_t2r <= wr_data[DLYW-1:0];
      else            dly_r2t <= wr_data[DLYW-1:0];
    end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [WIDTH-1:0] r_out, r_oe, r_mask, r_txv, r_rxv;
    wire hit = wr_en && !is_glb && wbank == BW'(b);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        r_out  <= '0;
        r_oe   <= '0;
        r_mask <= '0;
        r_txv  <= '0;
        r_rxv  <= '0;
      end else if (hit) begin
        case (wfld)
          3'd0:    r_out  <= (r_out  & ~wm) | (wv & wm);
          3'd1:    r_oe   <= (r_oe   & ~wm) | (wv & wm);
          3'd2:    r_mask <= (r_mask & ~wm) | (wv & wm);
          3'd3:    r_txv  <= (r_txv  & ~wm) | (wv & wm);
          3'd4:    r_rxv  <= (r_rxv  & ~wm) | (wv & wm);
          default: ;
        endcase
      end

    assign pin_out[b*WIDTH +: WIDTH] =
      (r_mask & (tx_mode ? r_txv : r_rxv)) | (~r_mask & r_out);
    assign pin_oe[b*WIDTH +: WIDTH] = r_oe;
  end

  always_comb
    rd_data = {pin_in[(2*int'(rd_sel)+1)*WIDTH +: WIDTH],
               pin_in[(2*int'(rd_sel))*WIDTH +: WIDTH]};

endmodule

// File: rtl/atr_gpio_ctrl_chk.sv
module atr_gpio_ctrl_chk #(
  parameter int NBANK = 4,
  parameter int WIDTH = 16,
  parameter int DLYW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [NBANK*WIDTH-1:0] pin_out,
  input logic [NBANK*WIDTH-1:0] pin_oe,
  input logic                   tx_mode,
  input logic                   ne_s,
  input logic [DLYW-1:0]        dly_r2t,
  input logic [DLYW-1:0]        dly_t2r
);

  a_r5_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));

  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(tx_mode) || $stable(pin_out)));

  a_r6_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mode) |-> $past(ne_s));

  a_r6_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_mode) |-> !$past(ne_s));

  a_r7_r2t_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_mode) && $past(dly_r2t) != '0) |-> $past(ne_s, 2));

  a_r7_t2r_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_mode) && $past(dly_t2r) != '0) |-> !$past(ne_s, 2));

endmodule

bind atr_gpio_ctrl atr_gpio_ctrl_chk #(.NBANK(NBANK), .WIDTH(WIDTH), .DLYW(DLYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pin_out(pin_out), .pin_oe(pin_oe),
  .tx_mode(tx_mode), .ne_s(ne_s), .dly_r2t(dly_r2t), .dly_t2r(dly_t2r));

// File: tb/test_atr_gpio_ctrl.sv
`timescale 1ns/1ps
module test_atr_gpio_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0, fifo_ne = 0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [0:0]  rd_sel = '0;
  logic [63:0] pin_out, pin_oe, pin_in = '0;

  atr_gpio_ctrl i_atr_gpio_ctrl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .fifo_ne(fifo_ne),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0;
  string ptag = "R2";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_out[4], m_oe[4], m_mask[4], m_tx[4], m_rx[4];
  int m_dr2t, m_dt2r, m_run;
  bit m_s1, m_s2, m_mode;

  function automatic logic [15:0] mw(input logic [15:0] old, input logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int b;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_out[i] <= 0; m_oe[i] <= 0; m_mask[i] <= 0; m_tx[i] <= 0; m_rx[i] <= 0;
      end
      m_dr2t <= 0; m_dt2r <= 0; m_run <= 0; m_s1 <= 0; m_s2 <= 0; m_mode <= 0;
    end else begin
      if (wr_en) begin
        if (wr_addr[5]) begin
          if (wr_addr[4:0] == 5'd0) m_dr2t <= int'(wr_data[15:0]);
          if (wr_addr[4:0] == 5'd1) m_dt2r <= int'(wr_data[15:0]);
        end else begin
          b = int'(wr_addr[4:3]);
          case (wr_addr[2:0])
            3'd0: m_out[b]  <= mw(m_out[b], wr_data);
            3'd1: m_oe[b]   <= mw(m_oe[b], wr_data);
            3'd2: m_mask[b] <= mw(m_mask[b], wr_data);
            3'd3: m_tx[b]   <= mw(m_tx[b], wr_data);
            3'd4: m_rx[b]   <= mw(m_rx[b], wr_data);
            default: ;
          endcase
        end
      end
      if (m_s2 != m_mode) begin
        if (m_run >= (m_s2 ? m_dr2t : m_dt2r)) begin
          m_mode <= m_s2; m_run <= 0;
        end else m_run <= m_run + 1;
      end else m_run <= 0;
      m_s2 <= m_s1;
      m_s1 <= fifo_ne;
    end
  end

  function automatic logic [63:0] exp_out();
    logic [63:0] v;
    for (int i = 0; i < 4; i++)
      v[i*16 +: 16] = (m_mask[i] & (m_mode ? m_tx[i] : m_rx[i])) | (~m_mask[i] & m_out[i]);
    return v;
  endfunction

  function automatic logic [63:0] exp_oe();
    logic [63:0] v;
    for (int i = 0; i < 4; i++) v[i*16 +: 16] = m_oe[i];
    return v;
  endfunction

  always begin
    @(posedge clk);
    #2;
    if (rst_n && cmp_on) begin
      chk(pin_oe == exp_oe(), "R5", pin_oe, exp_oe());
      chk(pin_out == exp_out(), ptag, pin_out, exp_out());
      chk(rd_data == {pin_in[(2*rd_sel+1)*16 +: 16], pin_in[(2*rd_sel)*16 +: 16]}, "R8",
          64'(rd_data), 64'({pin_in[(2*rd_sel+1)*16 +: 16], pin_in[(2*rd_sel)*16 +: 16]}));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    chk(pin_oe == 64'd0, "R1", pin_oe, 64'd0);
    chk(pin_out == 64'd0, "R1", pin_out, 64'd0);
    cmp_on = 1;
    @(negedge clk);

    // R2 masked writes on bank 1 output register
    ptag = "R2";
    wr(6'd8, 32'hFF00_1234);
    wr(6'd8, 32'h0F0F_ABCD);
    chk(pin_out[31:16] == 16'h1B0D, "R2", 64'(pin_out[31:16]), 64'h1B0D);

    // R9 unused field and unused global address
    ptag = "R9";
    wr(6'd13, 32'hFFFF_FFFF);
    wr(6'd34, 32'hFFFF_0007);
    chk(pin_out[31:16] == 16'h1B0D, "R9", 64'(pin_out[31:16]), 64'h1B0D);
    chk(pin_oe == 64'd0, "R9", pin_oe, 64'd0);

    // R6 synchroniser latency with zero delay, bank 0 fully switched
    ptag = "R6";
    wr(6'd1, 32'hFFFF_FFFF);
    wr(6'd2, 32'hFFFF_FFFF);
    wr(6'd3, 32'hFFFF_A5A5);
    wr(6'd4, 32'hFFFF_5A5A);
    fifo_ne = 1;
    @(negedge clk);
    chk(pin_out[15:0] == 16'h5A5A, "R6", 64'(pin_out[15:0]), 64'h5A5A);
    @(negedge clk);
    chk(pin_out[15:0] == 16'h5A5A, "R6", 64'(pin_out[15:0]), 64'h5A5A);
    @(negedge clk);
    chk(pin_out[15:0] == 16'hA5A5, "R4", 64'(pin_out[15:0]), 64'hA5A5);

    // R3 partial mask on bank 0, output register fills the rest
    ptag = "R3";
    wr(6'd2, 32'hFFFF_00FF);
    wr(6'd0, 32'hFFFF_C300);
    chk(pin_out[15:0] == 16'hC3A5, "R3", 64'(pin_out[15:0]), 64'hC3A5);
    fifo_ne = 0;
    repeat (4) @(negedge clk);
    chk(pin_out[15:0] == 16'hC35A, "R4", 64'(pin_out[15:0]), 64'hC35A);

    // R7 receive-to-transmit delay of 3
    ptag = "R7";
    wr(6'd32, 32'h0000_0003);
    fifo_ne = 1;
    repeat (5) @(negedge clk);
    chk(pin_out[15:0] == 16'hC35A, "R7", 64'(pin_out[15:0]), 64'hC35A);
    @(negedge clk);
    chk(pin_out[15:0] == 16'hC3A5, "R7", 64'(pin_out[15:0]), 64'hC3A5);
    // R7 cancelled change: transmit-to-receive delay 4, short low pulse
    wr(6'd33, 32'h0000_0004);
    fifo_ne = 0;
    repeat (2) @(negedge clk);
    fifo_ne = 1;
    repeat (10) @(negedge clk);
    chk(pin_out[15:0] == 16'hC3A5, "R7", 64'(pin_out[15:0]), 64'hC3A5);

    // random traffic checked against the model every cycle
    ptag = "R4";
    for (int n = 0; n < 3000; n++) begin
      pin_in = {$urandom, $urandom};
      rd_sel = 1'($urandom);
      if ($urandom % 4 == 0) fifo_ne = ~fifo_ne;
      if ($urandom % 3 == 0) begin
        wr_en = 1;
        wr_addr = 6'($urandom);
        wr_data = wr_addr[5] ? 32'($urandom % 5) : 32'($urandom);
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule